// File: doc/BRIEF.md
# DMA Page Permission Checker

This block guards the path from bus-mastering I/O devices into system memory. Each device-initiated access is presented with the requester's identifier, its physical address and a direction flag. The block resolves the requester to a protection domain through a small programmable table. It then reads the relevant word of that domain's exclusion bitmap from memory and answers with an allow or deny pulse. The bitmap is a single contiguous table with one bit for every 4 KiB page. It covers the whole physical address space, with no distinction between DRAM and device register space.

Only one request is handled at a time. The request port stays not-ready until the answer is produced. The last bitmap word fetched is kept in a one-entry cache, tagged by domain and word address, so repeated accesses to neighbouring pages skip the memory read. Software programs the requester table and the per-domain base and enable through a write-only configuration port. Every configuration write drops the cached word. On a denial, the offending requester, address and direction are latched for later inspection.

Top module: `dma_page_guard`

## Requirements
- R1: While reset is applied, and once it is released, `req_ready` is 1 and `rsp_valid`, `rsp_allow`, `rsp_fault`, `mem_req`, `flt_id`, `flt_addr` and `flt_write` are 0.
- R2: A configuration write with `cfg_kind`=0 programs the table entry for requester `cfg_idx`. Bit DOM_W of `cfg_wdata` marks the entry as mapped, and bits DOM_W-1:0 give the domain. A requester whose entry is unmapped is denied with a fault, and no memory read is issued.
- R3: A configuration write with `cfg_kind`=1 programs domain `cfg_idx[DOM_W-1:0]`. Bit 0 of `cfg_wdata` is the enable, and the base is `cfg_wdata` with its low log2(WORD_BYTES) bits cleared. A requester mapped to a disabled domain is allowed, and no memory read is issued.
- R4: For an enabled domain whose bitmap word is not cached, `mem_req` is high for exactly one cycle, the cycle after the clock edge that follows acceptance. `mem_addr` = base + ((addr >> 12) / WORD_BITS) * WORD_BYTES.
- R5: The bit used is bit ((addr >> 12) mod WORD_BITS) of the bitmap word. A 1 denies the access and a 0 allows it.
- R6: `req_write` has no effect on the decision or on the memory address: reads and writes to the same page receive the same answer.
- R7: `req_ready` drops after a request is accepted and returns to 1 in the cycle in which the response pulse is high, so only one request is ever in flight.
- R8: A request whose domain and bitmap word address match the cached word issues no memory read. Its response is high in the cycle after the second clock edge following the accepting edge. Requests resolved by R2 or R3 follow the same timing.
- R9: For a fetched word, the response is high in the cycle after the edge at which `mem_rvalid` is sampled high.
- R10: Any configuration write invalidates the cached word, so the next request to the same word fetches it again.
- R11: On every denial, `flt_id`, `flt_addr` and `flt_write` capture the denied request. They hold their values through later allowed requests.
- R12: `rsp_valid` is a single-cycle pulse. `rsp_fault` is high exactly when `rsp_valid` is high with `rsp_allow` low.
- R13: The cache tag includes the domain. Two domains with the same base therefore never share a cached word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 1 | 0: requester table entry, 1: domain base/enable |
| cfg_idx | input | ID_W | Requester or domain index |
| cfg_wdata | input | ADDR_W | Configuration write data |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_id | input | ID_W | Requester bus/device identifier |
| req_addr | input | ADDR_W | Physical address of the access |
| req_write | input | 1 | Direction flag, 1 for write |
| mem_req | output | 1 | Bitmap word read request pulse |
| mem_addr | output | ADDR_W | Byte address of the bitmap word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | WORD_BITS | Bitmap word |
| rsp_valid | output | 1 | Response pulse |
| rsp_allow | output | 1 | Access permitted |
| rsp_fault | output | 1 | Access denied |
| flt_id | output | ID_W | Requester of the last denied access |
| flt_addr | output | ADDR_W | Address of the last denied access |
| flt_write | output | 1 | Direction of the last denied access |

## Verification
The assertions watch the cycle-level rules on every clock. These are the single-cycle response and read pulses, the fault and deny agreement, the drop of ready after acceptance, the response following returned data, and the cache dropping its word after a configuration write. Whether the right bit of the right word was chosen, whether a hit really skips memory, and whether the fault record holds through allowed requests can only be shown by the bench's scenarios. These compare each response, read address and response cycle with values computed from the programmed tables.

// File: rtl/dpg_pkg.sv
package dpg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOOK  = 2'd1,
    ST_CHECK = 2'd2,
    ST_WAIT  = 2'd3
  } dpg_state_e;

  typedef enum logic [1:0] {
    RK_NOMAP = 2'd0,
    RK_OFF   = 2'd1,
    RK_HIT   = 2'd2,
    RK_MISS  = 2'd3
  } dpg_kind_e;

  localparam logic CFG_MAP = 1'b0;
  localparam logic CFG_DOM = 1'b1;

endpackage

// File: rtl/dpg_cfg_regs.sv
module dpg_cfg_regs #(
  parameter int ID_W       = 4,
  parameter int DOM_W      = 2,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_kind,
  input  logic [ID_W-1:0]   cfg_idx,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic [ID_W-1:0]   lk_id,
  output logic              lk_mapped,
  output logic [DOM_W-1:0]  lk_dom,
  output logic              lk_en,
  output logic [ADDR_W-1:0] lk_base
);
  import dpg_pkg::*;

  localparam int N_ID  = 1 << ID_W;
  localparam int N_DOM = 1 << DOM_W;
  localparam logic [ADDR_W-1:0] BASE_MASK = ~(ADDR_W'(WORD_BYTES) - ADDR_W'(1));

  logic             map_v [N_ID];
  logic [DOM_W-1:0] map_d [N_ID];
  logic             dom_e [N_DOM];
  logic [ADDR_W-1:0] dom_b [N_DOM];

  for (genvar g = 0; g < N_ID; g++) begin : g_map
    logic             v_q;
    logic [DOM_W-1:0] d_q;
    logic             wen;
    assign wen = cfg_we && (cfg_kind == CFG_MAP) && (cfg_idx == ID_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else if (wen) begin
        v_q <= cfg_wdata[DOM_W];
        d_q <= cfg_wdata[DOM_W-1:0];
      end
    end
    assign map_v[g] = v_q;
    assign map_d[g] = d_q;
  end

  for (genvar g = 0; g < N_DOM; g++) begin : g_dom
    logic              e_q;
    logic [ADDR_W-1:0] b_q;
    logic              wen;
    assign wen = cfg_we && (cfg_kind == CFG_DOM) && (cfg_idx[DOM_W-1:0] == DOM_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        e_q <= 1'b0;
        b_q <= '0;
      end else if (wen) begin
        e_q <= cfg_wdata[0];
        b_q <= cfg_wdata & BASE_MASK;
      end
    end
    assign dom_e[g] = e_q;
    assign dom_b[g] = b_q;
  end

  always_comb begin
    lk_mapped = map_v[lk_id];
    lk_dom    = map_d[lk_id];
    lk_en     = dom_e[lk_dom];
    lk_base   = dom_b[lk_dom];
  end

endmodule

// File: rtl/dpg_word_cache.sv
module dpg_word_cache #(
  parameter int DOM_W     = 2,
  parameter int ADDR_W    = 32,
  parameter int WORD_BITS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inval,
  input  logic                 fill,
  input  logic [DOM_W-1:0]     fill_dom,
  input  logic [ADDR_W-1:0]    fill_addr,
  input  logic [WORD_BITS-1:0] fill_data,
  input  logic [DOM_W-1:0]     lk_dom,
  input  logic [ADDR_W-1:0]    lk_addr,
  output logic                 lk_hit,
  output logic [WORD_BITS-1:0] lk_data,
  output logic                 vld
);

  logic                 vld_q, vld_d;
  logic [DOM_W-1:0]     dom_q, dom_d;
  logic [ADDR_W-1:0]    adr_q, adr_d;
  logic [WORD_BITS-1:0] dat_q, dat_d;
  logic                 ld_en;

  always_comb begin
    ld_en = fill && !inval;
    vld_d = inval ? 1'b0 : (fill ? 1'b1 : vld_q);
    dom_d = fill_dom;
    adr_d = fill_addr;
    dat_d = fill_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dom_q <= '0;
      adr_q <= '0;
      dat_q <= '0;
    end else if (ld_en) begin
      dom_q <= dom_d;
      adr_q <= adr_d;
      dat_q <= dat_d;
    end
  end

  assign lk_hit  = vld_q && (dom_q == lk_dom) && (adr_q == lk_addr);
  assign lk_data = dat_q;
  assign vld     = vld_q;

endmodule

// File: rtl/dpg_ctrl.sv
module dpg_ctrl #(
  parameter int ID_W       = 4,
  parameter int DOM_W      = 2,
  parameter int ADDR_W     = 32,
  parameter int WORD_BITS  = 32,
  parameter int WORD_BYTES = 4,
  parameter int PAGE_SHIFT = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ID_W-1:0]      req_id,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_write,
  output logic [ID_W-1:0]      lk_id,
  input  logic                 lk_mapped,
  input  logic [DOM_W-1:0]     lk_dom,
  input  logic                 lk_en,
  input  logic [ADDR_W-1:0]    lk_base,
  output logic [ADDR_W-1:0]    c_addr,
  input  logic                 c_hit,
  input  logic [WORD_BITS-1:0] c_data,
  output logic                 c_fill,
  output logic [DOM_W-1:0]     c_fill_dom,
  output logic                 mem_req,
  output logic [ADDR_W-1:0]    mem_addr,
  input  logic                 mem_rvalid,
  input  logic [WORD_BITS-1:0] mem_rdata,
  output logic                 rsp_valid,
  output logic                 rsp_allow,
  output logic                 rsp_fault,
  output logic [ID_W-1:0]      flt_id,
  output logic [ADDR_W-1:0]    flt_addr,
  output logic                 flt_write,
  output logic                 fetch_wait
);
  import dpg_pkg::*;

  localparam int BIT_W   = $clog2(WORD_BITS);
  localparam int BYTE_SH = $clog2(WORD_BYTES);

  dpg_state_e        st_q, st_d;
  dpg_kind_e         kind_q, kind_d;
  logic [ID_W-1:0]   id_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [DOM_W-1:0]  dom_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [BIT_W-1:0]  bidx_q;
  logic              bit_q;
  logic              rv_q, ra_q, rf_q;
  logic              rv_d, ra_d, rf_d;
  logic [ID_W-1:0]   fid_q;
  logic [ADDR_W-1:0] fadr_q;
  logic              fwr_q;

  logic              acc_en, look_en, flt_en;
  logic [ADDR_W-1:0] page, woff, waddr;
  logic [BIT_W-1:0]  bidx;

  // bitmap word address and bit position for the captured request
  always_comb begin
    page  = addr_q >> PAGE_SHIFT;
    woff  = (page >> BIT_W) << BYTE_SH;
    waddr = lk_base + woff;
    bidx  = page[BIT_W-1:0];
  end

  always_comb begin
    st_d    = st_q;
    kind_d  = kind_q;
    rv_d    = 1'b0;
    ra_d    = 1'b0;
    rf_d    = 1'b0;
    acc_en  = 1'b0;
    look_en = 1'b0;
    c_fill  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          acc_en = 1'b1;
          st_d   = ST_LOOK;
        end
      end
      ST_LOOK: begin
        look_en = 1'b1;
        if (!lk_mapped)  kind_d = RK_NOMAP;
        else if (!lk_en) kind_d = RK_OFF;
        else if (c_hit)  kind_d = RK_HIT;
        else             kind_d = RK_MISS;
        st_d = ST_CHECK;
      end
      ST_CHECK: begin
        if (kind_q == RK_MISS) begin
          st_d = ST_WAIT;
        end else begin
          rv_d = 1'b1;
          ra_d = (kind_q == RK_OFF) || ((kind_q == RK_HIT) && !bit_q);
          rf_d = !ra_d;
          st_d = ST_IDLE;
        end
      end
      ST_WAIT: begin
        if (mem_rvalid) begin
          c_fill = 1'b1;
          rv_d   = 1'b1;
          ra_d   = !mem_rdata[bidx_q];
          rf_d   = !ra_d;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    flt_en = rf_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= RK_NOMAP;
      rv_q   <= 1'b0;
      ra_q   <= 1'b0;
      rf_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
      rv_q   <= rv_d;
      ra_q   <= ra_d;
      rf_q   <= rf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q   <= '0;
      addr_q <= '0;
      wr_q   <= 1'b0;
    end else if (acc_en) begin
      id_q   <= req_id;
      addr_q <= req_addr;
      wr_q   <= req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dom_q   <= '0;
      waddr_q <= '0;
      bidx_q  <= '0;
      bit_q   <= 1'b0;
    end else if (look_en) begin
      dom_q   <= lk_dom;
      waddr_q <= waddr;
      bidx_q  <= bidx;
      bit_q   <= c_data[bidx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fid_q  <= '0;
      fadr_q <= '0;
      fwr_q  <= 1'b0;
    end else if (flt_en) begin
      fid_q  <= id_q;
      fadr_q <= addr_q;
      fwr_q  <= wr_q;
    end
  end

  assign req_ready  = (st_q == ST_IDLE);
  assign lk_id      = id_q;
  assign c_addr     = waddr;
  assign c_fill_dom = dom_q;
  assign mem_req    = (st_q == ST_CHECK) && (kind_q == RK_MISS);
  assign mem_addr   = waddr_q;
  assign rsp_valid  = rv_q;
  assign rsp_allow  = ra_q;
  assign rsp_fault  = rf_q;
  assign flt_id     = fid_q;
  assign flt_addr   = fadr_q;
  assign flt_write  = fwr_q;
  assign fetch_wait = (st_q == ST_WAIT);

endmodule

// File: rtl/dma_page_guard.sv
module dma_page_guard #(
  parameter int ID_W       = 4,
  parameter int DOM_W      = 2,
  parameter int ADDR_W     = 32,
  parameter int WORD_BITS  = 32,
  parameter int PAGE_SHIFT = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic                 cfg_kind,
  input  logic [ID_W-1:0]      cfg_idx,
  input  logic [ADDR_W-1:0]    cfg_wdata,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ID_W-1:0]      req_id,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_write,
  output logic                 mem_req,
  output logic [ADDR_W-1:0]    mem_addr,
  input  logic                 mem_rvalid,
  input  logic [WORD_BITS-1:0] mem_rdata,
  output logic                 rsp_valid,
  output logic                 rsp_allow,
  output logic                 rsp_fault,
  output logic [ID_W-1:0]      flt_id,
  output logic [ADDR_W-1:0]    flt_addr,
  output logic                 flt_write
);

  localparam int WORD_BYTES = WORD_BITS / 8;

  logic [1:0] rst_sync_q;
  logic       rst_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_q = rst_sync_q[1];

  logic [ID_W-1:0]      lk_id;
  logic                 lk_mapped, lk_en;
  logic [DOM_W-1:0]     lk_dom;
  logic [ADDR_W-1:0]    lk_base;
  logic [ADDR_W-1:0]    c_addr;
  logic                 c_hit, c_fill, cache_vld;
  logic [WORD_BITS-1:0] c_data;
  logic [DOM_W-1:0]     c_fill_dom;
  logic                 fetch_wait;

  dpg_cfg_regs #(
    .ID_W(ID_W), .DOM_W(DOM_W), .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n_q),
    .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .lk_id(lk_id), .lk_mapped(lk_mapped), .lk_dom(lk_dom), .lk_en(lk_en), .lk_base(lk_base)
  );

  dpg_word_cache #(
    .DOM_W(DOM_W), .ADDR_W(ADDR_W), .WORD_BITS(WORD_BITS)
  ) u_cache (
    .clk(clk), .rst_n(rst_n_q),
    .inval(cfg_we), .fill(c_fill), .fill_dom(c_fill_dom), .fill_addr(mem_addr),
    .fill_data(mem_rdata), .lk_dom(lk_dom), .lk_addr(c_addr),
    .lk_hit(c_hit), .lk_data(c_data), .vld(cache_vld)
  );

  dpg_ctrl #(
    .ID_W(ID_W), .DOM_W(DOM_W), .ADDR_W(ADDR_W), .WORD_BITS(WORD_BITS),
    .WORD_BYTES(WORD_BYTES), .PAGE_SHIFT(PAGE_SHIFT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n_q),
    .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id),
    .req_addr(req_addr), .req_write(req_write),
    .lk_id(lk_id), .lk_mapped(lk_mapped), .lk_dom(lk_dom), .lk_en(lk_en), .lk_base(lk_base),
    .c_addr(c_addr), .c_hit(c_hit), .c_data(c_data), .c_fill(c_fill), .c_fill_dom(c_fill_dom),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_fault(rsp_fault),
    .flt_id(flt_id), .flt_addr(flt_addr), .flt_write(flt_write), .fetch_wait(fetch_wait)
  );

endmodule

// File: rtl/dpg_checker.sv
module dpg_checker (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic mem_req,
  input logic mem_rvalid,
  input logic rsp_valid,
  input logic rsp_allow,
  input logic rsp_fault,
  input logic cfg_we,
  input logic cache_vld,
  input logic fetch_wait
);

  a_r7_hold_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r7_not_ready_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  a_r8_no_early_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !rsp_valid);

  a_r4_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  a_r9_data_to_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_wait && mem_rvalid) |=> rsp_valid);

  a_r10_cfg_drops_word: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !cache_vld);

  a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r12_fault_is_deny: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_valid && !rsp_allow));

  a_r12_deny_has_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_allow) |-> rsp_fault);

endmodule

bind dma_page_guard dpg_checker u_chk (
  .clk(clk), .rst_n(rst_n_q),
  .req_valid(req_valid), .req_ready(req_ready),
  .mem_req(mem_req), .mem_rvalid(mem_rvalid),
  .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_fault(rsp_fault),
  .cfg_we(cfg_we), .cache_vld(cache_vld), .fetch_wait(fetch_wait)
);

// File: tb/dma_page_guard_tb_top.sv
module dma_page_guard_tb_top;

  localparam int ID_W = 4;
  localparam int DOM_W = 2;
  localparam int AW = 32;
  localparam int WB = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we, cfg_kind;
  logic [ID_W-1:0] cfg_idx;
  logic [AW-1:0] cfg_wdata;
  logic          req_valid, req_ready, req_write;
  logic [ID_W-1:0] req_id;
  logic [AW-1:0] req_addr;
  logic          mem_req, mem_rvalid;
  logic [AW-1:0] mem_addr;
  logic [WB-1:0] mem_rdata;
  logic          rsp_valid, rsp_allow, rsp_fault, flt_write;
  logic [ID_W-1:0] flt_id;
  logic [AW-1:0] flt_addr;

  always #4 clk = ~clk;

  dma_page_guard dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id),
    .req_addr(req_addr), .req_write(req_write),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_fault(rsp_fault),
    .flt_id(flt_id), .flt_addr(flt_addr), .flt_write(flt_write)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  int dly     = 1;

  // reference state built from the requirements
  bit            m_ok  [16];
  logic [1:0]    m_dom [16];
  bit            d_en  [4];
  logic [AW-1:0] d_base[4];
  bit            cv;
  logic [1:0]    c_dom;
  logic [AW-1:0] c_addr;
  logic [ID_W-1:0] e_fid;
  logic [AW-1:0] e_faddr;
  bit            e_fwr;

  function automatic logic [WB-1:0] bm_word(input logic [AW-1:0] a);
    return a ^ {a[15:0], a[31:16]} ^ 32'hA5C3_0F96;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        chk(1'b0, "watchdog", 64'(cycles), 64'd100000);
        finish_run();
      end
    end
  end

  task automatic cfg_write(input bit kind, input int idx, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = kind; cfg_idx = ID_W'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (kind) begin
      d_en[idx % 4]   = d[0];
      d_base[idx % 4] = d & ~32'h3;
    end else begin
      m_ok[idx]  = d[DOM_W];
      m_dom[idx] = d[1:0];
    end
    cv = 1'b0;
  endtask

  task automatic run_req(input int id, input logic [AW-1:0] addr, input bit wr, input string tag);
    bit            e_allow, e_fetch, hit;
    logic [AW-1:0] e_waddr, f_addr;
    logic [WB-1:0] w;
    int            e_at, sched, fetches, rsp_at;
    bit            got, a_allow, a_fault, a_rdy;
    logic [19:0]   pg;
    pg = addr[31:12];
    e_fetch = 1'b0;
    e_waddr = '0;
    if (!m_ok[id]) e_allow = 1'b0;
    else if (!d_en[m_dom[id]]) e_allow = 1'b1;
    else begin
      e_waddr = d_base[m_dom[id]] + AW'((pg / 32) * 4);
      hit = cv && (c_dom == m_dom[id]) && (c_addr == e_waddr);
      if (!hit) begin
        e_fetch = 1'b1; cv = 1'b1; c_dom = m_dom[id]; c_addr = e_waddr;
      end
      w = bm_word(e_waddr);
      e_allow = !w[pg % 32];
    end
    e_at = e_fetch ? 3 + dly : 3;

    @(negedge clk);
    chk(req_ready == 1'b1, {"R7 ready before ", tag}, 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0, {"R12 idle pulse low ", tag}, 64'(rsp_valid), 64'd0);
    req_valid = 1'b1; req_id = ID_W'(id); req_addr = addr; req_write = wr;
    sched = -1; fetches = 0; got = 1'b0; rsp_at = 0; f_addr = '0;
    a_allow = 1'b0; a_fault = 1'b0; a_rdy = 1'b0;
    for (int i = 1; i < 40 && !got; i++) begin
      @(negedge clk);
      req_valid  = 1'b0;
      mem_rvalid = 1'b0;
      if (i == 1) chk(req_ready == 1'b0, {"R7 busy ", tag}, 64'(req_ready), 64'd0);
      if (mem_req) begin
        fetches++;
        f_addr = mem_addr;
        if (i != 2) chk(1'b0, {"R4 read cycle ", tag}, 64'(i), 64'd2);
        sched = i + dly;
      end
      if (i == sched) begin
        mem_rvalid = 1'b1;
        mem_rdata  = bm_word(f_addr);
      end
      if (rsp_valid) begin
        got = 1'b1; rsp_at = i;
        a_allow = rsp_allow; a_fault = rsp_fault; a_rdy = req_ready;
      end
    end
    mem_rvalid = 1'b0;
    chk(got, {"R8 response seen ", tag}, 64'(got), 64'd1);
    chk(rsp_at == e_at, {(e_fetch ? "R9" : "R8"), " response cycle ", tag}, 64'(rsp_at), 64'(e_at));
    chk(fetches == int'(e_fetch), {(e_fetch ? "R4" : "R8"), " read count ", tag}, 64'(fetches), 64'(e_fetch));
    if (e_fetch)
      chk(f_addr == e_waddr, {"R4 read address ", tag}, 64'(f_addr), 64'(e_waddr));
    chk(a_allow == e_allow, {"R5 decision ", tag}, 64'(a_allow), 64'(e_allow));
    chk(a_fault == !e_allow, {"R12 fault flag ", tag}, 64'(a_fault), 64'(!e_allow));
    chk(a_rdy == 1'b1, {"R7 ready with response ", tag}, 64'(a_rdy), 64'd1);
    if (!e_allow) begin
      e_fid = ID_W'(id); e_faddr = addr; e_fwr = wr;
    end
    chk({flt_id, flt_addr, flt_write} == {e_fid, e_faddr, e_fwr}, {"R11 fault record ", tag},
        64'({flt_id, flt_addr, flt_write}), 64'({e_fid, e_faddr, e_fwr}));
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_we = 1'b0; cfg_kind = 1'b0; cfg_idx = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_id = '0; req_addr = '0; req_write = 1'b0;
    mem_rvalid = 1'b0; mem_rdata = '0;
    for (int i = 0; i < 16; i++) begin m_ok[i] = 1'b0; m_dom[i] = '0; end
    for (int i = 0; i < 4; i++) begin d_en[i] = 1'b0; d_base[i] = '0; end
    cv = 1'b0; c_dom = '0; c_addr = '0;
    e_fid = '0; e_faddr = '0; e_fwr = 1'b0;

    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready in reset", 64'(req_ready), 64'd1);
    chk({rsp_valid, rsp_allow, rsp_fault, mem_req} == 4'b0, "R1 pulses low in reset",
        64'({rsp_valid, rsp_allow, rsp_fault, mem_req}), 64'd0);
    chk({flt_id, flt_addr, flt_write} == '0, "R1 fault record cleared",
        64'({flt_id, flt_addr, flt_write}), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req == 1'b0, "R1 state after release",
        64'({req_ready, rsp_valid, mem_req}), 64'b100);

    // unmapped requester before any programming
    run_req(5, 32'h0004_2000, 1'b0, "R2 unprogrammed");

    // requesters 0..11 mapped to domain id%4, 12..15 left unmapped
    for (int i = 0; i < 12; i++) cfg_write(1'b0, i, 32'(4 | (i % 4)));
    cfg_write(1'b1, 0, 32'h1000_0001);
    cfg_write(1'b1, 1, 32'h2000_0003);  // low bits cleared in base
    cfg_write(1'b1, 2, 32'h1000_0001);  // same base as domain 0
    cfg_write(1'b1, 3, 32'h3000_0000);  // disabled

    // near-exhaustive sweep: every requester, several pages, each twice
    for (int id = 0; id < 16; id++) begin
      for (int p = 0; p < 4; p++) begin
        logic [AW-1:0] a;
        a = (p == 3) ? 32'hFFFF_F7A4 : {12'(id * 37 + p * 5), 8'(p * 3), 12'(p * 291)};
        dly = 1 + ((id + p) % 3);
        run_req(id, a, p[0], "R3 R5 sweep first");
        run_req(id, a + 32'h40, !p[0], "R8 sweep repeat");
      end
    end

    // direction flag has no effect
    dly = 2;
    run_req(1, 32'h0123_4000, 1'b1, "R6 write");
    cfg_write(1'b0, 1, 32'h5);
    run_req(1, 32'h0123_4000, 1'b0, "R6 read refetch R10");

    // configuration write invalidates the cached word
    run_req(0, 32'h0777_7000, 1'b0, "R10 fill");
    run_req(0, 32'h0777_7000, 1'b0, "R10 hit");
    cfg_write(1'b0, 13, 32'h0);
    run_req(0, 32'h0777_7000, 1'b0, "R10 after write");

    // domains sharing a base do not share the cached word
    run_req(0, 32'h0999_9000, 1'b1, "R13 domain 0");
    run_req(2, 32'h0999_9000, 1'b1, "R13 domain 2");
    run_req(2, 32'h0999_9000, 1'b0, "R13 domain 2 again");

    // adjacent pages in one word hit, page in next word misses
    dly = 3;
    run_req(4, 32'h0000_0000, 1'b0, "R4 word 0 page 0");
    run_req(4, 32'h0001_F000, 1'b0, "R5 word 0 page 31");
    run_req(4, 32'h0002_0000, 1'b0, "R4 word 1 page 32");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule